// File: doc/BRIEF.md
# Interrupt Controller Command Decoder

This block is the programming front end of an eight-input interrupt controller. Software reaches it through a byte-wide port with a one-bit address and separate single-cycle write and read strobes. A write to address 0 is either the start of an initialization sequence, a control word (poll, readback selection, special mask) or an operation word (end-of-interrupt variants, priority rotation, rotate-on-auto-EOI). A write to address 1 is either a mask load or one of the later initialization words, depending on where the initialization sequencer currently is. The fourth initialization word is optional.

The block holds the configuration that the priority resolver needs: mask, vector base, auto-EOI, rotate-on-auto-EOI, special fully nested and special mask. It turns each operation word into a one-cycle command pulse with a line number. The request and in-service registers live in the resolver. The block only selects which one a read returns, or returns the resolver's poll response when a poll is pending. A separate select input reaches a trigger-mode register whose writable bits are fixed by a parameter. Bits 7:3 are writable on a master and bits 7,6,4,3,2,1 on a slave.

The interface has no data stream and no back-pressure. Every strobe is accepted in its own cycle. Pulses and read data are combinational with the strobe, and state changes are visible one cycle later.

Top module: `irq_cmd_decoder`

## Requirements
- R1: After reset, mask_o, vec_base_o, auto_eoi_o, rot_auto_eoi_o, nested_o, special_mask_o and trig_mode_o are all zero, the sequencer is idle, and no pulse is active.
- R2: A write with trig_sel=0, addr=0 and wdata[4]=1 pulses init_o in the same cycle. It clears mask, vector base, auto-EOI, rotate-on-auto-EOI, special fully nested, special mask, readback selection and pending poll. It stores wdata[0] as "fourth word expected" and moves the sequencer to its base-word state.
- R3: Address 1 writes (trig_sel=0) follow the sequencer. When idle, the write loads mask_o. In the base-word state, vec_base_o takes {wdata[7:3],3'b000} and the sequencer advances. In the third-word state, it moves to the fourth-word state if a fourth word was expected, otherwise back to idle. In the fourth-word state, nested_o takes wdata[4] and auto_eoi_o takes wdata[1], then the sequencer returns to idle. mask_o does not change while the sequencer is busy.
- R4: A write to address 0 with wdata[4]=0 and wdata[3]=1 is a control word. wdata[2]=1 sets a pending poll. When wdata[1]=1, wdata[0] picks the address-0 readback (1 = in-service, 0 = request). When wdata[6]=1, special_mask_o takes wdata[5].
- R5: A write to address 0 with wdata[4:3]=00 and wdata[7:5] equal to 0 or 4 sets rot_auto_eoi_o to wdata[7].
- R6: With wdata[4:3]=00, the opcode in wdata[7:5] drives exactly one pulse, only in the cycle of the write strobe. Opcode 1 drives ns_eoi_o, 5 drives rot_ns_eoi_o, 3 drives sp_eoi_o, 6 drives set_prio_o and 7 drives rot_sp_eoi_o. Opcode 2 and any cycle without a decoded write drive no pulse. line_o carries wdata[2:0] while a pulse is active and 0 otherwise.
- R7: During a read with trig_sel=0 and no poll pending, rdata returns mask_o at address 1, and irr_in or isr_in at address 0 as selected. rdata is 0 when rd_en is low. wr_en and rd_en are never high together.
- R8: A read with trig_sel=0 while a poll is pending returns poll_vec_in at either address, pulses poll_ack_o, and clears the pending poll.
- R9: A write with trig_sel=1 stores wdata ANDed with 8'hF8 (IS_SLAVE=0) or 8'hDE (IS_SLAVE=1) into trig_mode_o. It touches nothing else. A read with trig_sel=1 returns trig_mode_o. An initialization word leaves trig_mode_o unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| trig_sel | input | 1 | Access goes to the trigger-mode register |
| addr | input | 1 | Register address |
| wr_en | input | 1 | Write strobe, one cycle per write |
| rd_en | input | 1 | Read strobe, one cycle per read |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, valid while rd_en is high |
| irr_in | input | 8 | Request register from the resolver |
| isr_in | input | 8 | In-service register from the resolver |
| poll_vec_in | input | 8 | Poll response byte from the resolver |
| init_o | output | 1 | Initialization pulse, also drops the interrupt output |
| ns_eoi_o | output | 1 | Non-specific EOI pulse |
| rot_ns_eoi_o | output | 1 | Rotating non-specific EOI pulse |
| sp_eoi_o | output | 1 | Specific EOI pulse |
| set_prio_o | output | 1 | Set-priority pulse |
| rot_sp_eoi_o | output | 1 | Specific rotating EOI pulse |
| line_o | output | 3 | Line number for the active pulse |
| poll_ack_o | output | 1 | Poll acknowledge pulse |
| mask_o | output | 8 | Interrupt mask |
| vec_base_o | output | 8 | Vector base, low three bits zero |
| auto_eoi_o | output | 1 | Auto-EOI enabled |
| rot_auto_eoi_o | output | 1 | Rotate on auto-EOI |
| nested_o | output | 1 | Special fully nested mode |
| special_mask_o | output | 1 | Special mask mode |
| trig_mode_o | output | 8 | Trigger-mode register (1 = level) |

## Verification
The assertions assume that wr_en and rd_en are never high in the same cycle. That rule is itself checked, and it lets a poll acknowledge and a control word never compete for the pending-poll flag. The stimulus chooses one operation per cycle: a write, a read or an idle cycle. It never raises both strobes. Initialization words are biased in often enough that the sequencer keeps passing through its base, third and fourth states with random mask writes mixed in. Random trigger-register writes check the fixed writable bits on a master and a slave instance.

// File: rtl/icd_pkg.sv
package icd_pkg;
  localparam int BW     = 8;
  localparam int LINE_W = $clog2(BW);

  typedef enum logic [1:0] {
    SEQ_IDLE  = 2'd0,
    SEQ_BASE  = 2'd1,
    SEQ_WORD3 = 2'd2,
    SEQ_WORD4 = 2'd3
  } seq_state_e;

  typedef enum logic [2:0] {
    OP_ROT_CLR    = 3'd0,
    OP_NS_EOI     = 3'd1,
    OP_NOP        = 3'd2,
    OP_SP_EOI     = 3'd3,
    OP_ROT_SET    = 3'd4,
    OP_ROT_NS_EOI = 3'd5,
    OP_SET_PRIO   = 3'd6,
    OP_ROT_SP_EOI = 3'd7
  } opcode_e;

  typedef struct packed {
    logic ns_eoi;
    logic rot_ns_eoi;
    logic sp_eoi;
    logic set_prio;
    logic rot_sp_eoi;
  } cmd_pulse_t;
endpackage

// File: rtl/icd_init_seq.sv
module icd_init_seq
  import icd_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          acc_wr,
  input  logic          addr,
  input  logic [BW-1:0] wdata,
  output logic          init_pulse,
  output logic [BW-1:0] mask_q,
  output logic [BW-1:0] base_q,
  output logic          nested_q,
  output logic          aeoi_q
);
  seq_state_e state_q;
  logic       want4_q;
  logic       reg_wr;

  assign init_pulse = acc_wr && !addr && wdata[4];
  assign reg_wr     = acc_wr && addr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= SEQ_IDLE;
      want4_q  <= 1'b0;
      mask_q   <= '0;
      base_q   <= '0;
      nested_q <= 1'b0;
      aeoi_q   <= 1'b0;
    end else if (init_pulse) begin
      state_q  <= SEQ_BASE;
      want4_q  <= wdata[0];
      mask_q   <= '0;
      base_q   <= '0;
      nested_q <= 1'b0;
      aeoi_q   <= 1'b0;
    end else if (reg_wr) begin
      case (state_q)
        SEQ_IDLE:  mask_q <= wdata;
        SEQ_BASE: begin
          base_q  <= {wdata[BW-1:LINE_W], {LINE_W{1'b0}}};
          state_q <= SEQ_WORD3;
        end
        SEQ_WORD3: state_q <= want4_q ? SEQ_WORD4 : SEQ_IDLE;
        SEQ_WORD4: begin
          nested_q <= wdata[4];
          aeoi_q   <= wdata[1];
          state_q  <= SEQ_IDLE;
        end
        default:   state_q <= SEQ_IDLE;
      endcase
    end
  end

  AST_INIT_TO_BASE: assert property (@(posedge clk) disable iff (!rst_n)
    init_pulse |=> (state_q == SEQ_BASE)); // R2
  AST_INIT_CLEARS_MASK: assert property (@(posedge clk) disable iff (!rst_n)
    init_pulse |=> (mask_q == '0 && base_q == '0 && !aeoi_q && !nested_q)); // R2
  AST_MASK_HOLD_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q != SEQ_IDLE && !init_pulse) |=> $stable(mask_q)); // R3
  AST_WORD4_NEEDS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == SEQ_WORD3 && reg_wr && !init_pulse && !want4_q) |=> (state_q == SEQ_IDLE)); // R3
endmodule

// File: rtl/icd_cmd_dec.sv
module icd_cmd_dec
  import icd_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              acc_wr,
  input  logic              acc_rd,
  input  logic              addr,
  input  logic [BW-1:0]     wdata,
  input  logic              init_pulse,
  output cmd_pulse_t        pulses,
  output logic [LINE_W-1:0] line,
  output logic              poll_ack,
  output logic              poll_q,
  output logic              rd_isr_q,
  output logic              smm_q,
  output logic              rot_aeoi_q
);
  logic    ctl_hit;
  logic    op_hit;
  opcode_e opcode;

  assign ctl_hit  = acc_wr && !addr && !wdata[4] && wdata[3];
  assign op_hit   = acc_wr && !addr && !wdata[4] && !wdata[3];
  assign opcode   = opcode_e'(wdata[BW-1:BW-3]);
  assign poll_ack = acc_rd && poll_q;

  always_comb begin
    pulses = '0;
    if (op_hit) begin
      case (opcode)
        OP_NS_EOI:     pulses.ns_eoi     = 1'b1;
        OP_ROT_NS_EOI: pulses.rot_ns_eoi = 1'b1;
        OP_SP_EOI:     pulses.sp_eoi     = 1'b1;
        OP_SET_PRIO:   pulses.set_prio   = 1'b1;
        OP_ROT_SP_EOI: pulses.rot_sp_eoi = 1'b1;
        default:       pulses = '0;
      endcase
    end
  end

  assign line = (|pulses) ? wdata[LINE_W-1:0] : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      poll_q     <= 1'b0;
      rd_isr_q   <= 1'b0;
      smm_q      <= 1'b0;
      rot_aeoi_q <= 1'b0;
    end else if (init_pulse) begin
      poll_q     <= 1'b0;
      rd_isr_q   <= 1'b0;
      smm_q      <= 1'b0;
      rot_aeoi_q <= 1'b0;
    end else begin
      if (poll_ack) poll_q <= 1'b0;
      if (ctl_hit) begin
        if (wdata[2]) poll_q   <= 1'b1;
        if (wdata[1]) rd_isr_q <= wdata[0];
        if (wdata[6]) smm_q    <= wdata[5];
      end
      if (op_hit && (opcode == OP_ROT_CLR || opcode == OP_ROT_SET))
        rot_aeoi_q <= wdata[7];
    end
  end

  AST_PULSE_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(pulses)); // R6
  AST_PULSE_NEEDS_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (|pulses) |-> (acc_wr && !addr)); // R6
  AST_POLL_ACK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    poll_ack |=> !poll_q); // R8
  AST_INIT_CLEARS_CTL: assert property (@(posedge clk) disable iff (!rst_n)
    init_pulse |=> (!poll_q && !smm_q && !rot_aeoi_q && !rd_isr_q)); // R2
endmodule

// File: rtl/icd_trig_reg.sv
module icd_trig_reg
  import icd_pkg::*;
#(
  parameter logic [BW-1:0] WR_MASK = 8'hF8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr,
  input  logic [BW-1:0] wdata,
  output logic [BW-1:0] trig_q
);
  for (genvar i = 0; i < BW; i++) begin : g_bit
    if (WR_MASK[i]) begin : g_flop
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)  trig_q[i] <= 1'b0;
        else if (wr) trig_q[i] <= wdata[i];
      end
    end else begin : g_tie
      assign trig_q[i] = 1'b0;
    end
  end

  AST_TRIG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !wr |=> $stable(trig_q)); // R9
endmodule

// File: rtl/irq_cmd_decoder.sv
module irq_cmd_decoder
  import icd_pkg::*;
#(
  parameter bit             IS_SLAVE    = 1'b0,
  parameter logic [BW-1:0]  MASK_MASTER = 8'hF8,
  parameter logic [BW-1:0]  MASK_SLAVE  = 8'hDE
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              trig_sel,
  input  logic              addr,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [BW-1:0]     wdata,
  output logic [BW-1:0]     rdata,
  input  logic [BW-1:0]     irr_in,
  input  logic [BW-1:0]     isr_in,
  input  logic [BW-1:0]     poll_vec_in,
  output logic              init_o,
  output logic              ns_eoi_o,
  output logic              rot_ns_eoi_o,
  output logic              sp_eoi_o,
  output logic              set_prio_o,
  output logic              rot_sp_eoi_o,
  output logic [LINE_W-1:0] line_o,
  output logic              poll_ack_o,
  output logic [BW-1:0]     mask_o,
  output logic [BW-1:0]     vec_base_o,
  output logic              auto_eoi_o,
  output logic              rot_auto_eoi_o,
  output logic              nested_o,
  output logic              special_mask_o,
  output logic [BW-1:0]     trig_mode_o
);
  localparam logic [BW-1:0] TRIG_MASK = IS_SLAVE ? MASK_SLAVE : MASK_MASTER;

  logic       acc_wr, acc_rd, trig_wr;
  logic       poll_q, rd_isr_q;
  cmd_pulse_t pulses;

  assign acc_wr  = wr_en && !trig_sel;
  assign acc_rd  = rd_en && !trig_sel;
  assign trig_wr = wr_en && trig_sel;

  icd_init_seq u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .acc_wr     (acc_wr),
    .addr       (addr),
    .wdata      (wdata),
    .init_pulse (init_o),
    .mask_q     (mask_o),
    .base_q     (vec_base_o),
    .nested_q   (nested_o),
    .aeoi_q     (auto_eoi_o)
  );

  icd_cmd_dec u_dec (
    .clk        (clk),
    .rst_n      (rst_n),
    .acc_wr     (acc_wr),
    .acc_rd     (acc_rd),
    .addr       (addr),
    .wdata      (wdata),
    .init_pulse (init_o),
    .pulses     (pulses),
    .line       (line_o),
    .poll_ack   (poll_ack_o),
    .poll_q     (poll_q),
    .rd_isr_q   (rd_isr_q),
    .smm_q      (special_mask_o),
    .rot_aeoi_q (rot_auto_eoi_o)
  );

  icd_trig_reg #(.WR_MASK(TRIG_MASK)) u_trig (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr     (trig_wr),
    .wdata  (wdata),
    .trig_q (trig_mode_o)
  );

  assign ns_eoi_o     = pulses.ns_eoi;
  assign rot_ns_eoi_o = pulses.rot_ns_eoi;
  assign sp_eoi_o     = pulses.sp_eoi;
  assign set_prio_o   = pulses.set_prio;
  assign rot_sp_eoi_o = pulses.rot_sp_eoi;

  always_comb begin
    if (!rd_en)        rdata = '0;
    else if (trig_sel) rdata = trig_mode_o;
    else if (poll_q)   rdata = poll_vec_in;
    else if (addr)     rdata = mask_o;
    else               rdata = rd_isr_q ? isr_in : irr_in;
  end

  AST_STROBES_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && rd_en)); // R7
  AST_POLL_ACK_ON_READ: assert property (@(posedge clk) disable iff (!rst_n)
    poll_ack_o |-> (rd_en && !trig_sel)); // R8
  AST_INIT_KEEPS_TRIG: assert property (@(posedge clk) disable iff (!rst_n)
    init_o |=> $stable(trig_mode_o)); // R9
endmodule

// File: tb/sim_irq_cmd_decoder.sv
`timescale 1ns/1ps
module sim_irq_cmd_decoder;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       trig_sel = 1'b0, addr = 1'b0, wr_en = 1'b0, rd_en = 1'b0;
  logic [7:0] wdata = '0, irr_in = '0, isr_in = '0, poll_vec_in = '0;
  logic [7:0] rdata, mask_o, vec_base_o, trig_mode_o;
  logic       init_o, ns_eoi_o, rot_ns_eoi_o, sp_eoi_o, set_prio_o, rot_sp_eoi_o;
  logic [2:0] line_o;
  logic       poll_ack_o, auto_eoi_o, rot_auto_eoi_o, nested_o, special_mask_o;
  logic [7:0] s_rdata, s_mask, s_base, s_trig;
  logic       s_init, s_p0, s_p1, s_p2, s_p3, s_p4, s_ack, s_aeoi, s_rot, s_nest, s_smm;
  logic [2:0] s_line;

  always #2.5 clk = ~clk;

  irq_cmd_decoder u0 (
    .clk(clk), .rst_n(rst_n), .trig_sel(trig_sel), .addr(addr), .wr_en(wr_en),
    .rd_en(rd_en), .wdata(wdata), .rdata(rdata), .irr_in(irr_in), .isr_in(isr_in),
    .poll_vec_in(poll_vec_in), .init_o(init_o), .ns_eoi_o(ns_eoi_o),
    .rot_ns_eoi_o(rot_ns_eoi_o), .sp_eoi_o(sp_eoi_o), .set_prio_o(set_prio_o),
    .rot_sp_eoi_o(rot_sp_eoi_o), .line_o(line_o), .poll_ack_o(poll_ack_o),
    .mask_o(mask_o), .vec_base_o(vec_base_o), .auto_eoi_o(auto_eoi_o),
    .rot_auto_eoi_o(rot_auto_eoi_o), .nested_o(nested_o),
    .special_mask_o(special_mask_o), .trig_mode_o(trig_mode_o));

  irq_cmd_decoder #(.IS_SLAVE(1'b1)) u1 (
    .clk(clk), .rst_n(rst_n), .trig_sel(trig_sel), .addr(addr), .wr_en(wr_en),
    .rd_en(rd_en), .wdata(wdata), .rdata(s_rdata), .irr_in(irr_in), .isr_in(isr_in),
    .poll_vec_in(poll_vec_in), .init_o(s_init), .ns_eoi_o(s_p0),
    .rot_ns_eoi_o(s_p1), .sp_eoi_o(s_p2), .set_prio_o(s_p3),
    .rot_sp_eoi_o(s_p4), .line_o(s_line), .poll_ack_o(s_ack),
    .mask_o(s_mask), .vec_base_o(s_base), .auto_eoi_o(s_aeoi),
    .rot_auto_eoi_o(s_rot), .nested_o(s_nest),
    .special_mask_o(s_smm), .trig_mode_o(s_trig));

  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;

  // reference state
  logic [7:0] m_mask, m_base, m_trig, m_trig_s;
  logic       m_aeoi, m_rot, m_nest, m_smm, m_poll, m_rdisr, m_want4;
  int         m_state;

  task automatic chk(input string req, input string what, input logic [7:0] got, input logic [7:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s %s: got %h expected %h", req, what, got, exp);
    end
  endtask

  function automatic logic [7:0] exp_pulses(input logic [7:0] d, input logic a, input logic t, input logic w);
    logic [7:0] p = '0;
    if (w && !t && !a && !d[4] && !d[3]) begin
      case (d[7:5])
        3'd1: p[4] = 1'b1;
        3'd5: p[3] = 1'b1;
        3'd3: p[2] = 1'b1;
        3'd6: p[1] = 1'b1;
        3'd7: p[0] = 1'b1;
        default: p = '0;
      endcase
    end
    return p;
  endfunction

  function automatic logic [7:0] exp_read(input logic a, input logic t);
    if (t) return m_trig;
    if (m_poll) return poll_vec_in;
    if (a) return m_mask;
    return m_rdisr ? isr_in : irr_in;
  endfunction

  task automatic model_reset();
    m_mask = '0; m_base = '0; m_aeoi = 0; m_rot = 0; m_nest = 0; m_smm = 0;
    m_poll = 0; m_rdisr = 0; m_want4 = 0; m_state = 0;
  endtask

  task automatic check_cfg(input string req);
    chk(req, "mask", mask_o, m_mask);
    chk(req, "base", vec_base_o, m_base);
    chk(req, "flags", {3'b0, auto_eoi_o, rot_auto_eoi_o, nested_o, special_mask_o, 1'b0},
        {3'b0, m_aeoi, m_rot, m_nest, m_smm, 1'b0});
    chk("R9", "trig master", trig_mode_o, m_trig);
    chk("R9", "trig slave", s_trig, m_trig_s);
  endtask

  task automatic do_write(input logic t, input logic a, input logic [7:0] d);
    logic [7:0] ep;
    @(negedge clk);
    trig_sel = t; addr = a; wdata = d; wr_en = 1'b1; rd_en = 1'b0;
    #1;
    ep = exp_pulses(d, a, t, 1'b1);
    chk("R6", "pulses", {3'b0, ns_eoi_o, rot_ns_eoi_o, sp_eoi_o, set_prio_o, rot_sp_eoi_o}, ep);
    chk("R6", "line", {5'b0, line_o}, (ep != 0) ? {5'b0, d[2:0]} : 8'h00);
    chk("R2", "init pulse", {7'b0, init_o}, {7'b0, (!t && !a && d[4])});
    if (t) begin
      m_trig = d & 8'hF8; m_trig_s = d & 8'hDE;
    end else if (!a) begin
      if (d[4]) begin
        model_reset(); m_want4 = d[0]; m_state = 1;
      end else if (d[3]) begin
        if (d[2]) m_poll = 1;
        if (d[1]) m_rdisr = d[0];
        if (d[6]) m_smm = d[5];
      end else if (d[7:5] == 3'd0 || d[7:5] == 3'd4) m_rot = d[7];
    end else begin
      case (m_state)
        0: m_mask = d;
        1: begin m_base = {d[7:3], 3'b000}; m_state = 2; end
        2: m_state = m_want4 ? 3 : 0;
        default: begin m_nest = d[4]; m_aeoi = d[1]; m_state = 0; end
      endcase
    end
    @(negedge clk);
    wr_en = 1'b0;
    #1;
    check_cfg(t ? "R9" : (a ? "R3" : "R4"));
    chk("R6", "idle pulses", {2'b0, init_o, ns_eoi_o, rot_ns_eoi_o, sp_eoi_o, set_prio_o, rot_sp_eoi_o}, 8'h00);
  endtask

  task automatic do_read(input logic t, input logic a);
    logic poll_now;
    @(negedge clk);
    trig_sel = t; addr = a; rd_en = 1'b1; wr_en = 1'b0;
    irr_in = 8'($urandom); isr_in = 8'($urandom); poll_vec_in = 8'($urandom);
    #1;
    poll_now = m_poll && !t;
    chk(poll_now ? "R8" : (t ? "R9" : "R7"), "rdata", rdata, exp_read(a, t));
    chk("R8", "poll ack", {7'b0, poll_ack_o}, {7'b0, poll_now});
    if (t) chk("R9", "slave trig read", s_rdata, m_trig_s);
    if (poll_now) m_poll = 0;
    @(negedge clk);
    rd_en = 1'b0;
    #1;
    chk("R7", "idle rdata", rdata, 8'h00);
  endtask

  initial begin
    void'($urandom(32'h5EED_1234));
    model_reset(); m_trig = '0; m_trig_s = '0;
    repeat (3) @(negedge clk);
    #1;
    // R1 reset state
    check_cfg("R1");
    chk("R1", "pulses", {2'b0, init_o, ns_eoi_o, rot_ns_eoi_o, sp_eoi_o, set_prio_o, rot_sp_eoi_o}, 8'h00);
    rst_n = 1'b1;
    // R3 mask load while idle, then full four-word init
    do_write(0, 1, 8'hA5);
    do_write(1, 0, 8'hFF);          // R9 masked writes
    do_write(0, 0, 8'h11);          // R2 init, fourth word expected
    do_write(0, 1, 8'h4F);          // R3 base -> 0x48
    chk("R3", "base low zero", vec_base_o, 8'h48);
    do_write(0, 1, 8'h00);
    do_write(0, 1, 8'h12);          // R3 nested + aeoi
    chk("R3", "nested", {7'b0, nested_o}, 8'h01);
    do_write(0, 0, 8'h10);          // R2 init without fourth word
    do_write(0, 1, 8'h20);
    do_write(0, 1, 8'h00);
    do_write(0, 1, 8'h3C);          // R3 now a mask write
    chk("R3", "mask after 3 words", mask_o, 8'h3C);
    // R4 readback select and poll
    do_write(0, 0, 8'h0B); do_read(0, 0);
    do_write(0, 0, 8'h0A); do_read(0, 0);
    do_write(0, 0, 8'h0C); do_read(0, 1); do_read(0, 1);  // R8 poll then normal
    do_write(0, 0, 8'h68);          // R4 special mask on
    // R5, R6 every opcode
    for (int c = 0; c < 8; c++) do_write(0, 0, {c[2:0], 5'b00101});
    do_read(1, 0);
    // random mix
    for (int i = 0; i < 3000; i++) begin
      int k = $urandom_range(0, 15);
      logic [7:0] d = 8'($urandom);
      if (k == 0)       do_write(0, 0, d | 8'h10);
      else if (k < 5)   do_write(0, 0, d & 8'hEF);
      else if (k < 9)   do_write(0, 1, d);
      else if (k < 10)  do_write(1, $urandom_range(0, 1) != 0, d);
      else if (k < 14)  do_read(0, $urandom_range(0, 1) != 0);
      else if (k < 15)  do_read(1, 0);
      else begin @(negedge clk); #1; check_cfg("R1"); end
    end
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule